// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an internal request/acknowledge port and a byte-wide asynchronous static RAM that has fifteen address lines, eight shared data lines and active-low select, output-enable and write-strobe pins. It takes one read or write at a time and plays it out as a strobe sequence whose every interval is a whole number of system clock cycles. Each interval is computed at elaboration from a nanosecond figure and the clock period: the figure is divided by the period, rounded up, and never allowed below one cycle.

A read lowers select and output enable together and holds them for the longer of the address access time and the output-enable access time. The data lines are then captured into a result register, and a one-cycle acknowledge is raised alongside the captured byte. A write keeps output enable high from start to finish. It selects the memory and waits out the memory's output release time before it lowers the write strobe and turns on its own drivers. The low pulse is held for the longer of the pulse minimum and the data setup time. After the strobe rises, the drivers stay on for one further cycle so that the memory latches stable data. Between transfers every strobe is high and the drivers are off.

Top module: `sram_bus_ctl`

## Requirements
- R1: While reset is high, and in every idle cycle, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0 and req_ack is 0.
- R2: A read drives mem_ce_n=0 and mem_oe_n=0 with mem_we_n=1 for exactly ceil(max(55,25,55) ns / 8 ns) = 7 consecutive cycles at the default parameters.
- R3: At the end of the read window, rsp_rdata takes the value on mem_dq_in. req_ack is 1 for exactly one cycle, 8 clock cycles after the request is driven (accept edge + 7). rsp_rdata keeps its value until the next read completes, including across writes.
- R4: A write holds mem_oe_n=1 throughout and lowers mem_we_n for exactly ceil(max(45,25) ns / 8 ns) = 6 cycles, with mem_dq_oe=1 and req_wdata on mem_dq_out in every low cycle. mem_dq_oe stays 1 for the cycle in which mem_we_n returns high, so the byte is stored on that rising edge.
- R5: mem_we_n falls, and mem_dq_oe rises, exactly ceil(20 ns / 8 ns) = 3 cycles after mem_ce_n falls. The drivers are never enabled fewer than 3 cycles after mem_oe_n last went high.
- R6: mem_addr holds the accepted address and does not change while mem_ce_n is 0, including every cycle in which mem_we_n is 0.
- R7: A write acknowledges 11 clock cycles after the request is driven (accept edge + 10). This makes up a 3-cycle setup, a 6-cycle pulse and max(1, 7-6) = 1 hold cycle, and the ack comes only after mem_we_n has risen.
- R8: Changes to req_addr, req_write or req_wdata during a transfer have no effect on it. A request still present in the cycle where req_ack is 1 is not accepted, so mem_ce_n stays 1 in the next cycle.
- R9: mem_dq_oe is 1 only while mem_ce_n is 0 and mem_oe_n is 1, so the controller and the memory never drive the data lines together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset to idle |
| req_valid | input | 1 | Request present; held until req_ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address of the request |
| req_wdata | input | 8 | Byte to write |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read, valid with req_ack of a read |
| mem_addr | output | 15 | Memory address lines |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable of the data-line drivers |
| mem_dq_in | input | 8 | Data from the memory's lines |

## Verification
The assertions assume that reset is applied at the start. They also assume that the requester keeps req_valid high until it sees req_ack and then lowers it, apart from the one deliberate test in which it lingers a single cycle. The bench's memory model returns the complement of the stored byte until output enable has been low for the full access time. This keeps any early capture visible. The model stores a byte only on the rising write strobe, and it flags any moved address, undriven data or driver overlap. Random addresses, data and directions come from a fixed seed, and reads are aimed mostly at a small pool of recently written addresses. Directed cases cover the lowest and highest addresses, all-zero and all-one data, and request changes in mid-transfer.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WSETUP,
      ST_WPULSE,
      ST_WHOLD
   } seq_state_e;

   // nanoseconds to whole cycles, rounded up, never below one
   function automatic int ns_to_cycles(input int ns, input int period_ns);
      int c;
      c = (ns + period_ns - 1) / period_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_dpath.sv
module sram_dpath #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic [DATA_W-1:0] rsp_rdata
);

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;

   // request fields are taken only on the accept edge
   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         rdata_q <= '0;
      else if (capture)
         rdata_q <= mem_dq_in;
   end

   assign mem_addr   = addr_q;
   assign mem_dq_out = wdata_q;
   assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_bus_pkg::*;
#(
   parameter int CNT_W   = 4,
   parameter int RD_CYC  = 7,
   parameter int OEZ_CYC = 3,
   parameter int PUL_CYC = 6,
   parameter int HLD_CYC = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             tmr_done,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             accept,
   output logic             capture,
   output logic             req_ack,
   output logic             mem_ce_n,
   output logic             mem_oe_n,
   output logic             mem_we_n,
   output logic             mem_dq_oe
);

   localparam int MON_W = CNT_W + 1;

   seq_state_e st_q, st_d;
   logic       ack_q;

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      capture  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (req_valid && !ack_q) begin
               tmr_load = 1'b1;
               if (req_write) begin
                  st_d    = ST_WSETUP;
                  tmr_val = CNT_W'(OEZ_CYC - 1);
               end else begin
                  st_d    = ST_READ;
                  tmr_val = CNT_W'(RD_CYC - 1);
               end
            end
         end
         ST_READ: begin
            if (tmr_done) begin
               st_d    = ST_IDLE;
               capture = 1'b1;
            end
         end
         ST_WSETUP: begin
            if (tmr_done) begin
               st_d     = ST_WPULSE;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(PUL_CYC - 1);
            end
         end
         ST_WPULSE: begin
            if (tmr_done) begin
               st_d     = ST_WHOLD;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(HLD_CYC - 1);
            end
         end
         ST_WHOLD: begin
            if (tmr_done) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   assign accept = (st_q == ST_IDLE) && (st_d != ST_IDLE);

   // strobes are registered from the next state so they never glitch
   always_ff @(posedge clk) begin
      if (rst) begin
         st_q      <= ST_IDLE;
         ack_q     <= 1'b0;
         mem_ce_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_dq_oe <= 1'b0;
      end else begin
         st_q      <= st_d;
         ack_q     <= (st_q != ST_IDLE) && (st_d == ST_IDLE);
         mem_ce_n  <= (st_d == ST_IDLE);
         mem_oe_n  <= (st_d != ST_READ);
         mem_we_n  <= (st_d != ST_WPULSE);
         mem_dq_oe <= (st_d == ST_WPULSE) || (st_d == ST_WHOLD);
      end
   end

   assign req_ack = ack_q;

   // ---------------- checks on the pin sequence ----------------
   logic [MON_W-1:0] oe_hi_cnt, oe_lo_cnt, we_lo_cnt;
   localparam logic [MON_W-1:0] MON_MAX = '1;

   always_ff @(posedge clk) begin
      if (rst) begin
         oe_hi_cnt <= '0;
         oe_lo_cnt <= '0;
         we_lo_cnt <= '0;
      end else begin
         oe_hi_cnt <= !mem_oe_n ? '0 : (oe_hi_cnt == MON_MAX ? oe_hi_cnt : oe_hi_cnt + 1'b1);
         oe_lo_cnt <= mem_oe_n ? '0 : (oe_lo_cnt == MON_MAX ? oe_lo_cnt : oe_lo_cnt + 1'b1);
         we_lo_cnt <= mem_we_n ? '0 : (we_lo_cnt == MON_MAX ? we_lo_cnt : we_lo_cnt + 1'b1);
      end
   end

   a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
      mem_ce_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

   a_r2_read_window: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_oe_n) |-> (oe_lo_cnt == MON_W'(RD_CYC)));

   a_r3_ack_single: assert property (@(posedge clk) disable iff (rst)
      req_ack |=> !req_ack);

   a_r4_we_pulse: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_we_n) |-> (we_lo_cnt == MON_W'(PUL_CYC) && mem_dq_oe));

   a_r4_oe_off_in_write: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> mem_oe_n);

   a_r5_turnaround: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_dq_oe) |-> (oe_hi_cnt >= MON_W'(OEZ_CYC)));

   a_r9_no_fight: assert property (@(posedge clk) disable iff (rst)
      mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

endmodule

// File: rtl/sram_bus_ctl.sv
module sram_bus_ctl
   import sram_bus_pkg::*;
#(
   parameter int ADDR_W    = 15,
   parameter int DATA_W    = 8,
   parameter int CLK_NS    = 8,
   parameter int T_AA_NS   = 55,
   parameter int T_OEA_NS  = 25,
   parameter int T_RC_NS   = 55,
   parameter int T_WP_NS   = 45,
   parameter int T_DS_NS   = 25,
   parameter int T_WC_NS   = 55,
   parameter int T_OHZ_NS  = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ack,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int RD_CYC  = max_int(max_int(ns_to_cycles(T_AA_NS, CLK_NS),
                                            ns_to_cycles(T_OEA_NS, CLK_NS)),
                                    ns_to_cycles(T_RC_NS, CLK_NS));
   localparam int OEZ_CYC = ns_to_cycles(T_OHZ_NS, CLK_NS);
   localparam int PUL_CYC = max_int(ns_to_cycles(T_WP_NS, CLK_NS),
                                    ns_to_cycles(T_DS_NS, CLK_NS));
   localparam int WC_CYC  = ns_to_cycles(T_WC_NS, CLK_NS);
   localparam int HLD_CYC = max_int(1, WC_CYC - PUL_CYC);
   localparam int MAX_CYC = max_int(max_int(RD_CYC, OEZ_CYC), max_int(PUL_CYC, HLD_CYC));
   localparam int CNT_W   = max_int(1, $clog2(MAX_CYC + 1));

   if (CLK_NS < 1) begin : g_bad_clk
      $error("sram_bus_ctl: clock period must be positive");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_bus_ctl: address and data widths must be positive");
   end

   logic             tmr_load, tmr_done, accept, capture;
   logic [CNT_W-1:0] tmr_val;

   sram_cyc_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   sram_seq_fsm #(
      .CNT_W   (CNT_W),
      .RD_CYC  (RD_CYC),
      .OEZ_CYC (OEZ_CYC),
      .PUL_CYC (PUL_CYC),
      .HLD_CYC (HLD_CYC)
   ) i_fsm (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .req_write (req_write),
      .tmr_done  (tmr_done),
      .tmr_load  (tmr_load),
      .tmr_val   (tmr_val),
      .accept    (accept),
      .capture   (capture),
      .req_ack   (req_ack),
      .mem_ce_n  (mem_ce_n),
      .mem_oe_n  (mem_oe_n),
      .mem_we_n  (mem_we_n),
      .mem_dq_oe (mem_dq_oe)
   );

   sram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dpath (
      .clk        (clk),
      .rst        (rst),
      .accept     (accept),
      .capture    (capture),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .mem_dq_in  (mem_dq_in),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .rsp_rdata  (rsp_rdata)
   );

   a_r6_addr_hold: assert property (@(posedge clk) disable iff (rst)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   a_r7_ack_after_rise: assert property (@(posedge clk) disable iff (rst)
      (req_ack && !$past(mem_oe_n == 1'b0)) |-> $past(mem_we_n));

endmodule

// File: tb/test_sram_bus_ctl.sv
module test_sram_bus_ctl;

   localparam int CLK = 8;
   localparam int EXP_RD  = 7;   // ceil(55/8)
   localparam int EXP_PUL = 6;   // ceil(45/8)
   localparam int EXP_OEZ = 3;   // ceil(20/8)
   localparam int EXP_RD_LAT = EXP_RD + 1;
   localparam int EXP_WR_LAT = EXP_OEZ + EXP_PUL + 1 + 1;

   logic clk = 1'b0, rst = 1'b1;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [14:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic req_ack;
   logic [7:0] rsp_rdata, mem_dq_out, mem_dq_in;
   logic [14:0] mem_addr;
   logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;

   always #(CLK/2) clk = ~clk;

   sram_bus_ctl i_sram_bus_ctl (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
      .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // ---------------- memory model and pin monitor ----------------
   logic [7:0] model_mem [int];
   logic [7:0] ref_mem   [int];

   function automatic logic [7:0] init_val(input logic [14:0] a);
      return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
   endfunction

   function automatic logic [7:0] model_rd(input logic [14:0] a);
      return model_mem.exists(int'(a)) ? model_mem[int'(a)] : init_val(a);
   endfunction

   function automatic logic [7:0] ref_rd(input logic [14:0] a);
      return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_val(a);
   endfunction

   int rd_age = 0, last_rd_len = 0, we_age = 0, last_pulse = 0;
   int oe_hi_age = 100, ce_lo_age = 0, we_gap = 0;
   bit undriven = 0, addr_moved = 0, last_drive_ok = 0, fight = 0;
   logic [14:0] wr_addr;
   logic [7:0]  wr_data;

   always @(negedge clk) begin
      if (rst) begin
         rd_age = 0; we_age = 0; oe_hi_age = 100; ce_lo_age = 0;
         mem_dq_in = 8'h00;
      end else begin
         if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_age++;
         else begin
            if (rd_age > 0) last_rd_len = rd_age;
            rd_age = 0;
         end
         mem_dq_in = (rd_age >= EXP_RD) ? model_rd(mem_addr) : ~model_rd(mem_addr);
         oe_hi_age = mem_oe_n ? oe_hi_age + 1 : 0;
         ce_lo_age = mem_ce_n ? 0 : ce_lo_age + 1;
         if (mem_dq_oe && (!mem_oe_n || mem_ce_n || oe_hi_age < EXP_OEZ)) fight = 1;
         if (!mem_we_n && !mem_ce_n) begin
            if (we_age == 0) we_gap = ce_lo_age - 1;
            else if (mem_addr != wr_addr) addr_moved = 1;
            we_age++;
            if (!mem_dq_oe) undriven = 1;
            wr_addr = mem_addr;
            wr_data = mem_dq_out;
         end else if (we_age > 0) begin
            last_pulse    = we_age;
            last_drive_ok = !undriven && mem_dq_oe && (mem_dq_out == wr_data)
                            && (mem_addr == wr_addr);
            model_mem[int'(wr_addr)] = wr_data;
            we_age   = 0;
            undriven = 0;
         end
      end
   end

   // ---------------- request tasks ----------------
   task automatic wait_ack(output int lat);
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!req_ack && lat < 100);
   endtask

   task automatic do_read(input logic [14:0] a, input bit linger);
      int lat;
      logic [7:0] exp_d;
      exp_d = ref_rd(a);
      req_valid = 1; req_write = 0; req_addr = a; req_wdata = $urandom;
      wait_ack(lat);
      chk(lat == EXP_RD_LAT, "R3 read latency", lat, EXP_RD_LAT);
      chk(rsp_rdata == exp_d, "R3 read data", rsp_rdata, exp_d);
      if (!linger) req_valid = 0;
      @(negedge clk);
      req_valid = 0;
      chk(!req_ack, "R3 ack one cycle", req_ack, 0);
      chk(last_rd_len == EXP_RD, "R2 read window", last_rd_len, EXP_RD);
      if (linger) chk(mem_ce_n, "R8 no accept in ack cycle", mem_ce_n, 1);
   endtask

   task automatic do_write(input logic [14:0] a, input logic [7:0] d);
      int lat;
      logic [7:0] keep;
      keep = rsp_rdata;
      fight = 0; addr_moved = 0;
      req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
      ref_mem[int'(a)] = d;
      wait_ack(lat);
      req_valid = 0;
      chk(lat == EXP_WR_LAT, "R7 write latency", lat, EXP_WR_LAT);
      @(negedge clk);
      chk(last_pulse == EXP_PUL, "R4 strobe width", last_pulse, EXP_PUL);
      chk(last_drive_ok, "R4 data driven through rise", last_drive_ok, 1);
      chk(model_rd(a) == d, "R4 stored byte", model_rd(a), d);
      chk(we_gap == EXP_OEZ, "R5 select to strobe gap", we_gap, EXP_OEZ);
      chk(!addr_moved, "R6 address stable", addr_moved, 0);
      chk(!fight, "R9 no bus overlap", fight, 0);
      chk(rsp_rdata == keep, "R3 rdata held across write", rsp_rdata, keep);
   endtask

   task automatic idle_check(input string tag);
      chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ack,
          tag, {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ack}, 5'b11100);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [14:0] pool [16];
      int unused_seed;
      unused_seed = $urandom(32'h5EED);
      repeat (3) @(negedge clk);
      idle_check("R1 during reset");
      rst = 0;
      @(negedge clk);
      idle_check("R1 after reset");

      // directed corners
      do_write(15'h0000, 8'h00);
      do_write(15'h7FFF, 8'hFF);
      do_read(15'h0000, 0);
      do_read(15'h7FFF, 0);
      do_read(15'h1234, 1);              // R8 request lingers into ack cycle
      repeat (4) @(negedge clk);
      idle_check("R1 idle gap");

      // R8: change request fields while a read is in flight
      begin
         int lat;
         logic [7:0] before_b;
         before_b = model_rd(15'h0BEE);
         req_valid = 1; req_write = 0; req_addr = 15'h0ACE;
         @(negedge clk);
         req_addr = 15'h0BEE; req_write = 1; req_wdata = 8'h5A;
         @(negedge clk);
         chk(mem_addr == 15'h0ACE, "R8 address unchanged", mem_addr, 15'h0ACE);
         wait_ack(lat);
         req_valid = 0;
         chk(rsp_rdata == ref_rd(15'h0ACE), "R8 original read served", rsp_rdata, ref_rd(15'h0ACE));
         @(negedge clk);
         chk(model_rd(15'h0BEE) == before_b, "R8 no stray write", model_rd(15'h0BEE), before_b);
         idle_check("R1 after mid-change");
      end

      // constrained random
      for (int i = 0; i < 16; i++) pool[i] = 15'($urandom);
      for (int i = 0; i < 240; i++) begin
         logic [14:0] a;
         a = ($urandom % 4 == 0) ? 15'($urandom) : pool[$urandom % 16];
         if ($urandom % 2) do_write(a, 8'($urandom));
         else              do_read(a, 0);
         repeat ($urandom % 3) @(negedge clk);
      end
      for (int i = 0; i < 16; i++) do_read(pool[i], 0);

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule